// File: doc/BRIEF.md
# Host Data Bus Buffer Interface

This block is the slave-side host interface of a small I/O processor. It holds one byte the host has sent (the input buffer), one byte waiting for the host (the output buffer), and a status byte made of three flags: input-full, output-full and a general attention flag (flag 0). The host side reaches it through two addresses. Address 0 is the data port, read or written. Address 1 returns status on a read and takes a command code on a write.

The local processor loads the output buffer with a one-cycle load strobe and marks the input buffer as consumed with a one-cycle take strobe. It sees the input buffer, the last accepted command and the live status byte directly.

A status read has side effects. When flag 0 is set, the read returns the status as it stood and then clears one flag. Input-full is cleared first if set, otherwise output-full, otherwise flag 0 itself. This lets the host walk through a handshake with repeated status reads.

Top module: `hdb_iface`

## Requirements
- R1: The status byte has output-full at bit 0, input-full at bit 1 and flag 0 at bit 2; bits 7..3 read 0. `host_dout` is registered: it carries the result of a read in the cycle after the read strobe and holds its value otherwise.
- R2: A host read with `host_a0`=0 returns the output buffer byte and changes no flag.
- R3: A host write with `host_a0`=0 stores `host_din` in the input buffer (`loc_ibuf`) and sets input-full.
- R4: A host status read (`host_a0`=1) with flag 0 and input-full both set returns the status value before the read and clears input-full only.
- R5: A status read with flag 0 set, input-full clear and output-full set returns the prior status and clears output-full only.
- R6: A status read with flag 0 set and both buffer-full flags clear returns the prior status and clears flag 0.
- R7: A status read with flag 0 clear returns the status byte and clears nothing.
- R8: A host command write (`host_a0`=1) whose code lies in [CMD_BASE, CMD_BASE+CMD_NUM) (default 0x10 to 0x13) sets flag 0 and input-full and stores the code on `loc_cmd`.
- R9: A command code outside that range changes no flag and leaves `loc_cmd` unchanged.
- R10: `loc_load` stores `loc_din` in the output buffer and sets output-full. `loc_take` clears input-full. When a set and a clear of the same flag fall in one cycle, the set wins.
- R11: A synchronous active-high reset clears both buffers, the command byte, `host_dout` and all status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_a0 | input | 1 | 0 selects the data port, 1 the status/command port |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Registered host read data |
| loc_load | input | 1 | Local strobe: load output buffer |
| loc_din | input | 8 | Local byte for the output buffer |
| loc_take | input | 1 | Local strobe: input buffer consumed |
| loc_ibuf | output | 8 | Input buffer contents |
| loc_cmd | output | 8 | Last accepted command code |
| loc_status | output | 8 | Live status byte |

## Verification
Every strobe is registered once. Flags, buffers and `host_dout` therefore all show the effect of a strobe in the first cycle after the edge that samples it. The driver applies each operation for exactly one clock and then queues the expected output byte, status, input buffer and command. The monitor compares that entry at the following falling edge, after the update and before the next edge. The prioritized clearing is walked through step by step from a state with all three flags set, with a status read at each step. The command-range edges and a same-cycle write and take are covered as well.

// File: rtl/hdb_pkg.sv
package hdb_pkg;
    localparam int BYTE_W  = 8;
    localparam int OBF_BIT = 0;
    localparam int IBF_BIT = 1;
    localparam int F0_BIT  = 2;

    typedef logic [BYTE_W-1:0] hdb_byte_t;

    typedef struct packed {
        logic      ibf;
        logic      obf;
        logic      f0;
        hdb_byte_t ibuf;
        hdb_byte_t obuf;
        hdb_byte_t cmd;
        hdb_byte_t dout;
    } hdb_state_t;

    function automatic hdb_byte_t pack_status(logic ibf, logic obf, logic f0);
        hdb_byte_t s;
        s          = '0;
        s[OBF_BIT] = obf;
        s[IBF_BIT] = ibf;
        s[F0_BIT]  = f0;
        return s;
    endfunction
endpackage

// File: rtl/hdb_cmd_decode.sv
module hdb_cmd_decode
    import hdb_pkg::*;
#(
    parameter int CMD_BASE = 16,
    parameter int CMD_NUM  = 4
) (
    input  hdb_byte_t code_i,
    output logic      known_o
);
    localparam logic [BYTE_W:0] LO_C = (BYTE_W+1)'(CMD_BASE);
    localparam logic [BYTE_W:0] HI_C = (BYTE_W+1)'(CMD_BASE + CMD_NUM);

    logic [BYTE_W:0] code_ext;

    always_comb begin
        code_ext = {1'b0, code_i};
        known_o  = (code_ext >= LO_C) && (code_ext < HI_C);
    end
endmodule

// File: rtl/hdb_rdclr_sel.sv
module hdb_rdclr_sel (
    input  logic clk,
    input  logic rst,
    input  logic stat_rd_i,
    input  logic ibf_i,
    input  logic obf_i,
    input  logic f0_i,
    output logic clr_ibf_o,
    output logic clr_obf_o,
    output logic clr_f0_o
);
    logic armed;

    always_comb begin
        armed     = stat_rd_i && f0_i;
        clr_ibf_o = armed && ibf_i;
        clr_obf_o = armed && !ibf_i && obf_i;
        clr_f0_o  = armed && !ibf_i && !obf_i;
    end

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clr_ibf_o, clr_obf_o, clr_f0_o})); // R4
    AST_NO_CLEAR_WITHOUT_F0: assert property (@(posedge clk) disable iff (rst)
        !f0_i |-> !(clr_ibf_o || clr_obf_o || clr_f0_o)); // R7
endmodule

// File: rtl/hdb_iface.sv
module hdb_iface
    import hdb_pkg::*;
#(
    parameter int CMD_BASE = 16,
    parameter int CMD_NUM  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic       host_a0,
    input  logic [7:0] host_din,
    output logic [7:0] host_dout,
    input  logic       loc_load,
    input  logic [7:0] loc_din,
    input  logic       loc_take,
    output logic [7:0] loc_ibuf,
    output logic [7:0] loc_cmd,
    output logic [7:0] loc_status
);
    hdb_state_t st_d, st_q;
    hdb_byte_t  status_q;
    logic       cmd_known, cmd_ok, data_wr, stat_rd;
    logic       clr_ibf, clr_obf, clr_f0;

    hdb_cmd_decode #(
        .CMD_BASE (CMD_BASE),
        .CMD_NUM  (CMD_NUM)
    ) dec_i (
        .code_i  (host_din),
        .known_o (cmd_known)
    );

    hdb_rdclr_sel sel_i (
        .clk       (clk),
        .rst       (rst),
        .stat_rd_i (stat_rd),
        .ibf_i     (st_q.ibf),
        .obf_i     (st_q.obf),
        .f0_i      (st_q.f0),
        .clr_ibf_o (clr_ibf),
        .clr_obf_o (clr_obf),
        .clr_f0_o  (clr_f0)
    );

    always_comb begin
        status_q = pack_status(st_q.ibf, st_q.obf, st_q.f0);
        data_wr  = host_wr && !host_a0;
        stat_rd  = host_rd && host_a0;
        cmd_ok   = host_wr && host_a0 && cmd_known;

        st_d = st_q;
        if (host_rd) st_d.dout = host_a0 ? status_q : st_q.obuf;
        if (data_wr) st_d.ibuf = host_din;
        if (cmd_ok)  st_d.cmd  = host_din;
        if (loc_load) st_d.obuf = loc_din;

        st_d.ibf = (st_q.ibf && !clr_ibf && !loc_take) || data_wr || cmd_ok;
        st_d.obf = (st_q.obf && !clr_obf) || loc_load;
        st_d.f0  = (st_q.f0 && !clr_f0) || cmd_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign host_dout  = st_q.dout;
    assign loc_ibuf   = st_q.ibuf;
    assign loc_cmd    = st_q.cmd;
    assign loc_status = status_q;

    AST_STATUS_PAD_ZERO: assert property (@(posedge clk)
        loc_status[7:3] == 5'd0); // R1
    AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_dout)); // R1
    AST_DATA_RD_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        host_rd && !host_a0 && !host_wr && !loc_load && !loc_take |=> $stable(loc_status)); // R2
    AST_DATA_WR_SETS_IBF: assert property (@(posedge clk) disable iff (rst)
        host_wr && !host_a0 |=> loc_status[IBF_BIT]); // R3
    AST_STAT_RD_RETURNS_OLD: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_a0 |=> host_dout == $past(loc_status)); // R4
    AST_STAT_RD_CLR_IBF: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_a0 && loc_status[F0_BIT] && loc_status[IBF_BIT] && !host_wr
        |=> !loc_status[IBF_BIT] && loc_status[F0_BIT]); // R4
    AST_STAT_RD_CLR_OBF: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_a0 && loc_status[F0_BIT] && !loc_status[IBF_BIT]
        && loc_status[OBF_BIT] && !host_wr && !loc_load
        |=> !loc_status[OBF_BIT] && loc_status[F0_BIT]); // R5
    AST_STAT_RD_CLR_F0: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_a0 && loc_status[2:0] == 3'b100 && !host_wr
        |=> !loc_status[F0_BIT]); // R6
    AST_LOAD_SETS_OBF: assert property (@(posedge clk) disable iff (rst)
        loc_load |=> loc_status[OBF_BIT]); // R10
endmodule

// File: tb/hdb_iface_tb_top.sv
module hdb_iface_tb_top;
    typedef struct {
        string      req;
        logic [7:0] dout;
        logic [7:0] stat;
        logic [7:0] ibuf;
        logic [7:0] cmd;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rd = 0, host_wr = 0, host_a0 = 0, loc_load = 0, loc_take = 0;
    logic [7:0] host_din = 0, loc_din = 0;
    logic [7:0] host_dout, loc_ibuf, loc_cmd, loc_status;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];

    logic       m_ibf = 0, m_obf = 0, m_f0 = 0;
    logic [7:0] m_ibuf = 0, m_obuf = 0, m_cmd = 0, m_dout = 0;

    always #2.5 clk = ~clk;

    hdb_iface dut_i (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_a0(host_a0), .host_din(host_din), .host_dout(host_dout),
        .loc_load(loc_load), .loc_din(loc_din), .loc_take(loc_take),
        .loc_ibuf(loc_ibuf), .loc_cmd(loc_cmd), .loc_status(loc_status)
    );

    function automatic logic [7:0] m_stat();
        return {5'd0, m_f0, m_ibf, m_obf};
    endfunction

    task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.req, "host_dout", host_dout, e.dout);
            cmp(e.req, "loc_status", loc_status, e.stat);
            cmp(e.req, "loc_ibuf", loc_ibuf, e.ibuf);
            cmp(e.req, "loc_cmd", loc_cmd, e.cmd);
        end
    end

    task automatic op(string req, logic rd, logic wr, logic a0, logic [7:0] din,
                      logic ld, logic [7:0] ldin, logic tk);
        logic known, c_ibf, c_obf, c_f0;
        exp_t e;
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_a0 = a0; host_din = din;
        loc_load = ld; loc_din = ldin; loc_take = tk;
        known = (din >= 8'h10) && (din <= 8'h13);
        c_ibf = rd && a0 && m_f0 && m_ibf;
        c_obf = rd && a0 && m_f0 && !m_ibf && m_obf;
        c_f0  = rd && a0 && m_f0 && !m_ibf && !m_obf;
        if (rd) m_dout = a0 ? m_stat() : m_obuf;
        if (wr && !a0) m_ibuf = din;
        if (wr && a0 && known) m_cmd = din;
        m_ibf = (m_ibf && !c_ibf && !tk) || (wr && !a0) || (wr && a0 && known);
        m_obf = (m_obf && !c_obf) || ld;
        m_f0  = (m_f0 && !c_f0) || (wr && a0 && known);
        if (ld) m_obuf = ldin;
        @(posedge clk);
        #1;
        e.req = req; e.dout = m_dout; e.stat = m_stat(); e.ibuf = m_ibuf; e.cmd = m_cmd;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        host_rd = 0; host_wr = 0; host_a0 = 0; loc_load = 0; loc_take = 0;
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                rst = 1'b0;
                op("R11", 0, 0, 0, 8'h00, 0, 8'h00, 0);   // reset state
                op("R3",  0, 1, 0, 8'hA5, 0, 8'h00, 0);   // data write
                op("R10", 0, 0, 0, 8'h00, 0, 8'h00, 1);   // take clears in-full
                op("R10", 0, 0, 0, 8'h00, 1, 8'h3C, 0);   // load sets out-full
                op("R2",  1, 0, 0, 8'h00, 0, 8'h00, 0);   // data read
                op("R7",  1, 0, 1, 8'h00, 0, 8'h00, 0);   // status read, f0 clear
                op("R9",  0, 1, 1, 8'h55, 0, 8'h00, 0);   // unknown code
                op("R8",  0, 1, 1, 8'h12, 0, 8'h00, 0);   // known code
                op("R4",  1, 0, 1, 8'h00, 0, 8'h00, 0);   // clears in-full
                op("R5",  1, 0, 1, 8'h00, 0, 8'h00, 0);   // clears out-full
                op("R6",  1, 0, 1, 8'h00, 0, 8'h00, 0);   // clears f0
                op("R7",  1, 0, 1, 8'h00, 0, 8'h00, 0);   // nothing left
                op("R9",  0, 1, 1, 8'h0F, 0, 8'h00, 0);   // below range
                op("R9",  0, 1, 1, 8'h14, 0, 8'h00, 0);   // above range
                op("R8",  0, 1, 1, 8'h10, 0, 8'h00, 0);   // lowest code
                op("R10", 0, 0, 0, 8'h00, 0, 8'h00, 1);   // take clears in-full
                op("R6",  1, 0, 1, 8'h00, 0, 8'h00, 0);   // only f0 set
                op("R8",  0, 1, 1, 8'h13, 0, 8'h00, 0);   // highest code
                op("R10", 0, 1, 0, 8'h77, 0, 8'h00, 1);   // write and take, set wins
                op("R1",  0, 0, 0, 8'h00, 0, 8'h00, 0);   // dout holds
                op("R2",  1, 0, 0, 8'h00, 1, 8'h9E, 0);   // read old obuf during load
                op("R2",  1, 0, 0, 8'h00, 0, 8'h00, 0);   // new obuf
                idle();
                op("R11", 0, 0, 0, 8'h00, 0, 8'h00, 0);   // steady before reset
                @(negedge clk);
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                m_ibf = 0; m_obf = 0; m_f0 = 0;
                m_ibuf = 0; m_obuf = 0; m_cmd = 0; m_dout = 0;
                op("R11", 0, 0, 0, 8'h00, 0, 8'h00, 0);   // cleared by reset
                idle();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule